// File: doc/BRIEF.md
# Packed-Lane Shift, Rotate and Permute Unit

This block operates on a 64-bit packed operand. It can shift or rotate each lane on its own, with the lane width set to 16, 32 or 64 bits. It also offers two permutes. The first rearranges the four halfwords under an 8-bit selector. The second takes eight consecutive bytes out of two operands joined end to end. Alongside every result the block produces a 32-bit condition word that carries a negative and a zero indication for each lane of the result.

A caller presents the operands, the operation code, the lane width and an 8-bit control value, then raises `in_valid` for one cycle. The control value is a shift or rotate count, a shuffle selector or a byte offset, depending on the operation. One clock later, `result` and `flags` carry the registered answer and `out_valid` pulses. Between operations the outputs keep their last value.

Top module: `simd_shift_unit`

## Requirements
- R1: `result`, `flags` and `out_valid` reset to zero under synchronous active-high `rst`. They are loaded on the first rising edge after a cycle with `in_valid` high, at which point `out_valid` is high for that one cycle. Without `in_valid`, `result` and `flags` hold and `out_valid` is low.
- R2: Operation codes are 0 left shift, 1 logical right shift, 2 arithmetic right shift, 3 rotate right, 4 halfword shuffle and 5 byte align. Codes 6 and 7 return `opnd_a` unchanged and use the 64-bit condition format. Lane codes are 0 for 16-bit lanes, 1 for 32-bit lanes, and 2 or 3 for one 64-bit lane. A left shift drops the bits that leave a lane and fills the vacated bits with zero.
- R3: A logical right shift acts within each lane: zeros enter at the top, and bits never move into the next lower lane.
- R4: An arithmetic right shift copies each lane's own top bit into the vacated positions. A count at or above the lane width gives every bit of the lane equal to that top bit.
- R5: For both logical shifts, a count of zero returns the operand unchanged and a count at or above the lane width gives zero.
- R6: A rotate right by n moves the low n bits of each lane into the top n bits of the same lane. The count is taken modulo the lane width.
- R7: In the shuffle, result halfword k (bits 16k+15..16k) is the source halfword whose index is held in `ctl[2k+1:2k]`. The lane code has no effect, and the flags use the 16-bit format.
- R8: The byte align returns the low 64 bits of {`opnd_b`, `opnd_a`} shifted right by 8·`ctl[2:0]` bits. The higher bits of `ctl` are ignored, an offset of zero returns `opnd_a`, and the flags use the 64-bit format.
- R9: In the 16-bit format, lane i sets bit 8i+7 to its top bit and bit 8i+6 when the lane is zero. In the 32-bit format the same two indications sit at bits 16i+15 and 16i+14. In the 64-bit format they sit at bits 31 and 30. Every other bit of `flags` is zero.
- R10: `opnd_b` has no effect on any operation other than the byte align.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| lane_sel | input | 2 | Lane width select |
| opnd_a | input | 64 | Primary operand |
| opnd_b | input | 64 | Upper operand for byte align |
| ctl | input | 8 | Count, shuffle selector or byte offset |
| out_valid | output | 1 | Result strobe, one cycle |
| result | output | 64 | Registered result |
| flags | output | 32 | Registered per-lane N/Z word |

## Verification
The block keeps no state except the output register, so any fault in the lane logic shows up in `result` or `flags` on the cycle right after the strobe. The vectors are chosen so that a leak across a lane boundary, a wrong fill value or a mishandled count turns a known lane into a wrong nonzero value, or clears or sets a zero flag. A fault in the enable or the hold shows up as a change in the outputs during idle cycles, or as a missing `out_valid` pulse.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    localparam int DATA_W = 64;
    localparam int CNT_W  = 8;
    localparam int FLAG_W = DATA_W / 2;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_SIZES = 3;

    typedef enum logic [2:0] {
        OP_SHL   = 3'd0,
        OP_SHR   = 3'd1,
        OP_ASR   = 3'd2,
        OP_ROR   = 3'd3,
        OP_SHUF  = 3'd4,
        OP_ALIGN = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } sh_op_e;

    typedef enum logic [1:0] {
        FMT_16 = 2'd0,
        FMT_32 = 2'd1,
        FMT_64 = 2'd2
    } flag_fmt_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
    } sh_out_t;

    function automatic logic is_lane_op(sh_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ASR) || (op == OP_ROR);
    endfunction

    function automatic flag_fmt_e size_to_fmt(logic [1:0] sz);
        case (sz)
            2'd0:    return FMT_16;
            2'd1:    return FMT_32;
            default: return FMT_64;
        endcase
    endfunction

    function automatic int fmt_lane_bits(flag_fmt_e f);
        return HALF_W << int'(f);
    endfunction

endpackage

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
    import simd_shift_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int LANE_W   = 16,
    parameter int CNT_W_P  = CNT_W
) (
    input  sh_op_e                op,
    input  logic [DATA_W_P-1:0]   din,
    input  logic [CNT_W_P-1:0]    cnt,
    output logic [DATA_W_P-1:0]   dout
);
    localparam int LANES = DATA_W_P / LANE_W;
    localparam int ROT_W = $clog2(LANE_W);

    logic over;
    assign over = (cnt >= CNT_W_P'(LANE_W));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0]   x;
        logic [LANE_W-1:0]   y;
        logic [2*LANE_W-1:0] dbl;

        assign x   = din[l*LANE_W +: LANE_W];
        assign dbl = {x, x} >> cnt[ROT_W-1:0];

        always_comb begin
            case (op)
                OP_SHL:  y = over ? '0 : (x << cnt);
                OP_SHR:  y = over ? '0 : (x >> cnt);
                OP_ASR:  y = over ? {LANE_W{x[LANE_W-1]}} : LANE_W'($signed(x) >>> cnt);
                OP_ROR:  y = dbl[LANE_W-1:0];
                default: y = x;
            endcase
        end

        assign dout[l*LANE_W +: LANE_W] = y;
    end

endmodule

// File: rtl/simd_perm_unit.sv
module simd_perm_unit
    import simd_shift_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int CNT_W_P  = CNT_W
) (
    input  sh_op_e              op,
    input  logic [DATA_W_P-1:0] a,
    input  logic [DATA_W_P-1:0] b,
    input  logic [CNT_W_P-1:0]  ctl,
    output logic [DATA_W_P-1:0] dout
);
    localparam int HW_CNT   = DATA_W_P / HALF_W;
    localparam int SEL_W    = $clog2(HW_CNT);
    localparam int BOFS_W   = $clog2(DATA_W_P / BYTE_W);
    localparam int BSHIFT_W = BOFS_W + $clog2(BYTE_W);

    logic [DATA_W_P-1:0]   shuf;
    logic [2*DATA_W_P-1:0] cat;
    logic [BSHIFT_W-1:0]   bshift;

    for (genvar k = 0; k < HW_CNT; k++) begin : g_hw
        logic [SEL_W-1:0] idx;
        assign idx = ctl[k*SEL_W +: SEL_W];
        assign shuf[k*HALF_W +: HALF_W] = a[int'(idx)*HALF_W +: HALF_W];
    end

    assign bshift = {ctl[BOFS_W-1:0], {$clog2(BYTE_W){1'b0}}};
    assign cat    = {b, a} >> bshift;

    always_comb begin
        case (op)
            OP_SHUF:  dout = shuf;
            OP_ALIGN: dout = cat[DATA_W_P-1:0];
            default:  dout = a;
        endcase
    end

endmodule

// File: rtl/simd_flag_gen.sv
module simd_flag_gen
    import simd_shift_pkg::*;
#(
    parameter int DATA_W_P = DATA_W
) (
    input  flag_fmt_e             fmt,
    input  logic [DATA_W_P-1:0]   din,
    output logic [DATA_W_P/2-1:0] flags
);
    localparam int FW = DATA_W_P / 2;

    logic [FW-1:0] fw [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_fmt
        localparam int W    = HALF_W << g;
        localparam int LN   = DATA_W_P / W;
        localparam int SLOT = W / 2;
        always_comb begin
            fw[g] = '0;
            for (int i = 0; i < LN; i++) begin
                fw[g][SLOT*i + SLOT-1] = din[W*i + W-1];
                fw[g][SLOT*i + SLOT-2] = (din[W*i +: W] == '0);
            end
        end
    end

    always_comb begin
        case (fmt)
            FMT_16:  flags = fw[0];
            FMT_32:  flags = fw[1];
            default: flags = fw[2];
        endcase
    end

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
    import simd_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [CNT_W-1:0]  ctl,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    sh_op_e            op;
    flag_fmt_e         lane_fmt;
    flag_fmt_e         out_fmt;
    logic [DATA_W-1:0] shf_res [N_SIZES];
    logic [DATA_W-1:0] perm_res;
    logic [DATA_W-1:0] nxt_res;
    logic [FLAG_W-1:0] nxt_flg;
    sh_out_t           q;

    assign op       = sh_op_e'(op_code);
    assign lane_fmt = size_to_fmt(lane_sel);

    for (genvar g = 0; g < N_SIZES; g++) begin : g_shf
        simd_lane_shifter #(
            .DATA_W_P (DATA_W),
            .LANE_W   (HALF_W << g),
            .CNT_W_P  (CNT_W)
        ) u_shf (
            .op   (op),
            .din  (opnd_a),
            .cnt  (ctl),
            .dout (shf_res[g])
        );
    end

    simd_perm_unit #(
        .DATA_W_P (DATA_W),
        .CNT_W_P  (CNT_W)
    ) u_perm (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .ctl  (ctl),
        .dout (perm_res)
    );

    always_comb begin
        if (is_lane_op(op)) begin
            nxt_res = shf_res[lane_fmt];
            out_fmt = lane_fmt;
        end else if (op == OP_SHUF) begin
            nxt_res = perm_res;
            out_fmt = FMT_16;
        end else if (op == OP_ALIGN) begin
            nxt_res = perm_res;
            out_fmt = FMT_64;
        end else begin
            nxt_res = opnd_a;
            out_fmt = FMT_64;
        end
    end

    simd_flag_gen #(
        .DATA_W_P (DATA_W)
    ) u_flg (
        .fmt   (out_fmt),
        .din   (nxt_res),
        .flags (nxt_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) begin
                q.res <= nxt_res;
                q.flg <= nxt_flg;
            end
        end
    end

    assign out_valid = q.vld;
    assign result    = q.res;
    assign flags     = q.flg;

    // Assertion helpers
    logic [CNT_W:0] lane_bits;
    assign lane_bits = (CNT_W+1)'(fmt_lane_bits(lane_fmt));

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flags))); // R1
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_SHL || op == OP_SHR) && ctl == '0)
        |=> result == $past(opnd_a)); // R5
    AST_LOGIC_OVER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_SHL || op == OP_SHR) && {1'b0, ctl} >= lane_bits)
        |=> result == '0); // R5
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_ALIGN && ctl[2:0] == 3'd0)
        |=> result == $past(opnd_a)); // R8
    AST_NZ_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((flags & (flags << 1)) == '0)); // R9

endmodule

// File: tb/simd_shift_unit_bench.sv
module simd_shift_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_code;
    logic [1:0]  lane_sel;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic [7:0]  ctl;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] flags;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    simd_shift_unit u_simd_shift_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .lane_sel  (lane_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .ctl       (ctl),
        .out_valid (out_valid),
        .result    (result),
        .flags     (flags)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  c;
        logic [63:0] res;
        logic [31:0] flg;
    } vec_t;

    localparam logic [63:0] A0 = 64'h8001_4000_0000_FFFF;
    localparam logic [63:0] AB = 64'h0706_0504_0302_0100;
    localparam logic [63:0] BB = 64'h0F0E_0D0C_0B0A_0908;
    localparam int NV = 18;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, A0, 64'h0, 8'd1,  64'h0002_8000_0000_FFFE, 32'h0080_4080}, // R2 R9
        '{3'd1, 2'd0, A0, 64'h0, 8'd4,  64'h0800_0400_0000_0FFF, 32'h0000_4000}, // R3
        '{3'd2, 2'd0, A0, 64'h0, 8'd4,  64'hF800_0400_0000_FFFF, 32'h8000_4080}, // R4
        '{3'd3, 2'd0, A0, 64'h0, 8'd17, 64'hC000_2000_0000_FFFF, 32'h8000_4080}, // R6
        '{3'd0, 2'd1, A0, 64'h0, 8'd4,  64'h0014_0000_000F_FFF0, 32'h0000_0000}, // R2
        '{3'd1, 2'd2, A0, 64'h0, 8'd8,  64'h0080_0140_0000_00FF, 32'h0000_0000}, // R3
        '{3'd2, 2'd2, A0, 64'h0, 8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000}, // R4
        '{3'd0, 2'd0, A0, 64'h0, 8'd16, 64'h0,                   32'h4040_4040}, // R5 R9
        '{3'd4, 2'd0, A0, 64'h0, 8'h1B, 64'hFFFF_0000_4000_8001, 32'h8040_0080}, // R7
        '{3'd5, 2'd0, AB, BB,    8'd3,  64'h0A09_0807_0605_0403, 32'h0000_0000}, // R8
        '{3'd3, 2'd1, 64'h0000_0001_8000_0000, 64'h0, 8'd4,
                                        64'h1000_0000_0800_0000, 32'h0000_0000}, // R6
        '{3'd2, 2'd1, A0, 64'h0, 8'd40, 64'hFFFF_FFFF_0000_0000, 32'h8000_4000}, // R4 R9
        '{3'd3, 2'd2, 64'h18, 64'h0, 8'd4,
                                        64'h8000_0000_0000_0001, 32'h8000_0000}, // R6
        '{3'd0, 2'd3, A0, 64'h0, 8'd0,  A0,                      32'h8000_0000}, // R2 R5
        '{3'd6, 2'd0, A0, 64'h0, 8'd5,  A0,                      32'h8000_0000}, // R2
        '{3'd5, 2'd0, AB, BB,    8'd8,  AB,                      32'h0000_0000}, // R8
        '{3'd4, 2'd1, A0, 64'h0, 8'h1B, 64'hFFFF_0000_4000_8001, 32'h8040_0080}, // R7
        '{3'd2, 2'd0, A0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4,
                                        64'hF800_0400_0000_FFFF, 32'h8000_4080}  // R10
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] b, input logic [7:0] c);
        @(negedge clk);
        op_code  = op;
        lane_sel = sz;
        opnd_a   = a;
        opnd_b   = b;
        ctl      = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        op_code  = '0;
        lane_sel = '0;
        opnd_a   = '0;
        opnd_b   = '0;
        ctl      = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 reset out_valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset result", result, 64'h0);
        check("R1 reset flags", {32'h0, flags}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, VECS[i].c);
            check($sformatf("R1 vec %0d out_valid", i), {63'h0, out_valid}, 64'h1);
            check($sformatf("vec %0d result", i), result, VECS[i].res);
            check($sformatf("R9 vec %0d flags", i), {32'h0, flags}, {32'h0, VECS[i].flg});
        end

        // R1 hold while idle after the last vector
        repeat (2) @(negedge clk);
        check("R1 idle out_valid", {63'h0, out_valid}, 64'h0);
        check("R1 idle result held", result, 64'hF800_0400_0000_FFFF);
        check("R1 idle flags held", {32'h0, flags}, 64'h8000_4080);

        // R1 inputs changed without strobe are not captured
        @(negedge clk);
        op_code = 3'd0; lane_sel = 2'd0; opnd_a = 64'h1111_1111_1111_1111; ctl = 8'd0;
        @(negedge clk);
        @(negedge clk);
        check("R1 no strobe no capture", result, 64'hF800_0400_0000_FFFF);

        // R3 logical right shift in 16-bit lanes does not leak into lower lane
        apply(3'd1, 2'd0, 64'h0001_0001_0001_0001, 64'h0, 8'd1);
        check("R3 no cross-lane", result, 64'h0);
        check("R9 all lanes zero", {32'h0, flags}, 64'h4040_4040);

        // R6 rotate by lane width is identity
        apply(3'd3, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0, 8'd32);
        check("R6 rotate full width", result, 64'h1234_5678_9ABC_DEF0);

        // R8 offset 7 takes top byte of a then low bytes of b
        apply(3'd5, 2'd2, AB, BB, 8'hFF);
        check("R8 offset 7", result, 64'h0E0D_0C0B_0A09_0807);

        // R1 reset clears outputs mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset result", result, 64'h0);
        check("R1 mid-run reset flags", {32'h0, flags}, 64'h0);

        finish_run();
    end

endmodule